// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple memory-mapped register bus. The port data register is reached through a 256-word address window. Address bits [9:2] of each access act as a per-pin mask, so software can sample or change any chosen subset of pins in a single access. It never needs a read-modify-write sequence and never programs a mask register.

A separate direction register, outside the window, selects per pin whether the port drives it. The pad side receives the data register on an output bus with a matching output-enable bus. Pin levels come back through a two-stage synchroniser before software can see them. Read data is registered: it appears on the cycle after the read access and stays there until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: Byte offsets 0x000 to 0x3FC (bus_addr[11:10] = 00) form the data window; within it bus_addr[n+2] is the mask bit for pin n.
- R2: A read in the window returns, for each pin whose mask bit is 1, that pin's value, and 0 for each pin whose mask bit is 0 (offset 0x0C4, mask 0x31, exposes only pins 0, 4 and 5).
- R3: The value read for a pin is the data register bit when its direction bit is 1, and the synchronised pad level when it is 0; a pad change becomes visible to a read issued two clock edges after the change, and not to one issued after a single edge.
- R4: A write in the window changes only the data bits whose mask bit is 1 and leaves all others unchanged (writing 0xEB at offset 0x098, mask 0x26, onto a cleared register gives 0x22).
- R5: The direction register sits at byte offset 0x400; it is written and read as all eight bits with no masking, and 1 makes a pin an output; pad_oe shows the direction register and pad_out the data register.
- R6: bus_addr[1:0] has no effect; bus_rdata[31:8] is always 0; reads of any offset that is neither the window nor the direction register return 0, and writes there change nothing.
- R7: After reset the data register, the direction register and bus_rdata are all 0 (all pins inputs).
- R8: bus_rdata changes only on the clock edge that ends a read access and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_out | output | 8 | Values driven to the pads |
| pad_oe | output | 8 | Per-pin output enable |

## Verification
The assertions take for granted that each access is one cycle long: bus_sel is sampled with bus_wr, bus_addr and bus_wdata on a single edge, so an access is complete on that edge. They put no constraint on pad_in, because the synchronised value is never compared directly at the ports. The stimulus drives every access for exactly one cycle. It changes pad_in only between accesses and then waits at least two edges before checking a read, except in the one directed step that measures the synchroniser latency. Addresses are drawn separately from the window, the direction word and the unused space, with random low address bits.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Default geometry of the port.
    localparam int unsigned GPM_PINS       = 8;
    localparam int unsigned GPM_ADDR_W     = 12;
    localparam int unsigned GPM_BUS_W      = 32;
    localparam int unsigned GPM_SYNC_DEPTH = 2;
    localparam logic [11:0] GPM_DIR_OFFS   = 12'h400;

    // Classification of the target of a bus access.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_DIR   = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int unsigned PINS     = 8,
    parameter int unsigned ADDR_W   = 12,
    parameter logic [11:0] DIR_OFFS = 12'h400
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [PINS-1:0]   mask
);

    localparam int unsigned MASK_LSB = 2;
    localparam int unsigned WIN_TOP  = PINS + MASK_LSB;

    logic [ADDR_W-1:0] dir_addr;
    logic              in_window;
    logic              is_dir;
    logic [1:0]        unused_byte_lane;

    assign dir_addr         = ADDR_W'(DIR_OFFS);
    assign in_window        = (addr[ADDR_W-1:WIN_TOP] == '0);
    assign is_dir           = (addr[ADDR_W-1:MASK_LSB] == dir_addr[ADDR_W-1:MASK_LSB]);
    assign mask             = addr[WIN_TOP-1:MASK_LSB];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        if (!sel) begin
            kind = ACC_NONE;
        end else if (in_window) begin
            kind = ACC_DATA;
        end else if (is_dir) begin
            kind = ACC_DIR;
        end else begin
            kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int unsigned PINS  = 8,
    parameter int unsigned BUS_W = 32
) (
    input  acc_kind_e        kind,
    input  logic [PINS-1:0]  mask,
    input  logic [PINS-1:0]  data_reg,
    input  logic [PINS-1:0]  dir_reg,
    input  logic [PINS-1:0]  pin_sync,
    output logic [BUS_W-1:0] word
);

    logic [PINS-1:0] pin_view;

    // Per pin: output pins reflect the register, input pins the pad.
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pin_view[p] = dir_reg[p] ? data_reg[p] : pin_sync[p];
    end

    always_comb begin
        word = '0;
        unique case (kind)
            ACC_DATA: word[PINS-1:0] = pin_view & mask;
            ACC_DIR:  word[PINS-1:0] = dir_reg;
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned PINS       = GPM_PINS,
    parameter int unsigned ADDR_W     = GPM_ADDR_W,
    parameter int unsigned BUS_W      = GPM_BUS_W,
    parameter int unsigned SYNC_DEPTH = GPM_SYNC_DEPTH,
    parameter logic [11:0] DIR_OFFS   = GPM_DIR_OFFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    typedef struct packed {
        logic [PINS-1:0]  data;
        logic [PINS-1:0]  dir;
        logic [BUS_W-1:0] rdata;
    } port_state_t;

    port_state_t     st_d, st_q;
    acc_kind_e       acc_kind;
    logic [PINS-1:0] acc_mask;
    logic [PINS-1:0] pin_sync;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata;

    gpio_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_addr_decode #(
        .PINS     (PINS),
        .ADDR_W   (ADDR_W),
        .DIR_OFFS (DIR_OFFS)
    ) u_decode (
        .sel  (bus_sel),
        .addr (bus_addr),
        .kind (acc_kind),
        .mask (acc_mask)
    );

    gpio_read_mux #(
        .PINS  (PINS),
        .BUS_W (BUS_W)
    ) u_rmux (
        .kind     (acc_kind),
        .mask     (acc_mask),
        .data_reg (st_q.data),
        .dir_reg  (st_q.dir),
        .pin_sync (pin_sync),
        .word     (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (acc_kind != ACC_NONE) begin
            if (bus_wr) begin
                unique case (acc_kind)
                    ACC_DATA: st_d.data = (st_q.data & ~acc_mask)
                                        | (bus_wdata[PINS-1:0] & acc_mask);
                    ACC_DIR:  st_d.dir  = bus_wdata[PINS-1:0];
                    default:  ;
                endcase
            end else begin
                st_d.rdata = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.data;
    assign pad_oe    = st_q.dir;

endmodule

// File: rtl/gpio_mask_port_checker.sv
module gpio_mask_port_checker #(
    parameter int unsigned PINS     = 8,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BUS_W    = 32,
    parameter logic [11:0] DIR_OFFS = 12'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);

    localparam int unsigned TOP = PINS + 2;

    logic [ADDR_W-1:0] dir_word;
    logic              win_hit;
    logic              dir_hit;
    logic [PINS-1:0]   amask;

    assign dir_word = ADDR_W'(DIR_OFFS);
    assign win_hit  = bus_sel && (bus_addr[ADDR_W-1:TOP] == '0);
    assign dir_hit  = bus_sel && (bus_addr[ADDR_W-1:2] == dir_word[ADDR_W-1:2]);
    assign amask    = bus_addr[TOP-1:2];

    // R7: cleared state on the first cycle after reset release
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    // R4: masked write merges old and new bits
    a_r4_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(win_hit && bus_wr) |->
        pad_out == (($past(pad_out) & ~$past(amask)) | ($past(bus_wdata[PINS-1:0]) & $past(amask))));

    // R4 / R6: data register is untouched by anything but a window write
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(win_hit && bus_wr) |-> $stable(pad_out));

    // R5: direction write takes all bits
    a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dir_hit && bus_wr) |-> pad_oe == $past(bus_wdata[PINS-1:0]));

    // R5 / R6: direction register changes only on its own write
    a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dir_hit && bus_wr) |-> $stable(pad_oe));

    // R2: unmasked bits of a window read are zero
    a_r2_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(win_hit && !bus_wr) |->
        (bus_rdata[PINS-1:0] & ~$past(amask)) == '0);

    // R5: direction read returns the direction register
    a_r5_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dir_hit && !bus_wr) |-> bus_rdata[PINS-1:0] == $past(pad_oe));

    // R6: upper read bits are always zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PINS] == '0);

    // R8: read data holds without a read access
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

endmodule

bind gpio_mask_port gpio_mask_port_checker #(
    .PINS     (PINS),
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W),
    .DIR_OFFS (DIR_OFFS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_data = '0;
    logic [7:0] m_dir  = '0;

    always #2.5 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [7:0] pads);
        logic [7:0] view;
        view = (m_dir & m_data) | (~m_dir & pads);
        if (a[11:10] == 2'b00) return {24'h0, view & a[9:2]};
        if (a[11:2] == 10'h100) return {24'h0, m_dir};
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
        if (a[11:10] == 2'b00) m_data = (m_data & ~a[9:2]) | (d[7:0] & a[9:2]);
        else if (a[11:2] == 10'h100) m_dir = d[7:0];
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] r);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 0;
        r = bus_rdata;
    endtask

    task automatic set_pads(input logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R7: reset state
        check("R7 pad_out", {24'h0, pad_out}, 32'h0);
        check("R7 pad_oe", {24'h0, pad_oe}, 32'h0);
        check("R7 rdata", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check("R7 after release", {16'h0, pad_oe, pad_out}, 32'h0);

        // R3: synchroniser latency, pins are inputs
        @(negedge clk); pad_in = 8'hA5;
        @(posedge clk); #1;
        do_read(12'h3FC, r);
        check("R3 one edge old", r, 32'h0);
        do_read(12'h3FC, r);
        check("R3 two edges new", r, 32'hA5);

        // R2: offset 0x0C4 exposes pins 0,4,5
        set_pads(8'hFF);
        do_read(12'h0C4, r);
        check("R2 mask 0x31", r, 32'h31);
        set_pads(8'hEB);
        do_read(12'h0C4, r);
        check("R2 mask 0x31 on 0xEB", r, 32'h21);

        // R5: direction register full write/read
        do_write(12'h400, 32'hFFFF_FFFF);
        check("R5 pad_oe", {24'h0, pad_oe}, 32'hFF);
        do_read(12'h400, r);
        check("R5 dir read", r, 32'hFF);

        // R4: 0xEB at 0x098 onto cleared register
        do_write(12'h098, 32'h0000_00EB);
        check("R4 pad_out 0x22", {24'h0, pad_out}, 32'h22);
        do_read(12'h3FC, r);
        check("R3 output pins read register", r, 32'h22);

        // R1: single-bit masks walk the pins
        for (int p = 0; p < 8; p++) begin
            do_write(12'(4 << p), 32'hFF);
            check("R1 walking mask", {24'h0, pad_out}, {24'h0, m_data});
        end
        check("R1 all set", {24'h0, pad_out}, 32'hFF);

        // R6: low address bits ignored, outside space inert
        do_write(12'h003, 32'h0);
        check("R6 addr[1:0] ignored on write", {24'h0, pad_out}, 32'hFF);
        do_write(12'h802, 32'h0);
        do_write(12'h404, 32'h0);
        check("R6 outside write data", {24'h0, pad_out}, 32'hFF);
        check("R6 outside write dir", {24'h0, pad_oe}, 32'hFF);
        do_read(12'h9FC, r);
        check("R6 outside read zero", r, 32'h0);
        do_read(12'h403, r);
        check("R6 dir read with low bits", r, 32'hFF);

        // R8: read data holds across writes and idle cycles
        do_read(12'h3FC, held);
        do_write(12'h3FC, 32'h0);
        repeat (3) @(posedge clk);
        #1;
        check("R8 rdata held", bus_rdata, held);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            logic [11:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            d  = $urandom;
            case ($urandom_range(0, 3))
                0, 1: a = {2'b00, 8'($urandom), 2'($urandom)};
                2:    a = {10'h100, 2'($urandom)};
                default: a = 12'h800 | 12'($urandom & 32'h7FF);
            endcase
            if (op == 0) begin
                set_pads(8'($urandom));
            end else if (op <= 4) begin
                do_write(a, d);
                check("R4 random write pad_out", {24'h0, pad_out}, {24'h0, m_data});
                check("R5 random write pad_oe", {24'h0, pad_oe}, {24'h0, m_dir});
            end else begin
                do_read(a, r);
                check("R2 random read", r, exp_read(a, pad_in));
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule